// File: doc/BRIEF.md
# Line test pattern generator

This block sits in the transmit path of one T1/E1-style line channel. It picks the serial bit that goes to the line encoder, one bit per bit-enable strobe. The source is either the user's transmit data or a built-in maintenance pattern. The maintenance patterns are a steady mark (all ones), a steady space (all zeros) and a pseudo-random test sequence. The random sequence is a 15-stage maximal-length PRBS for E1 lines. For T1/J1 lines it is a 20-stage quasi-random signal whose zero runs are capped.

Four controls pick the pattern:

- a 2-bit pattern select;
- an alternate-source bit, which turns the pass-through code into an all-zeros code;
- a line-mode bit, which chooses between the two generators;
- an invert bit, which complements the random pattern.

Both generators run freely on every strobe. Switching between them therefore never restarts a sequence. The output is a combinational function of the generator state and the controls.

Top module: `line_pattern_gen`

## Requirements
- R1: A synchronous reset loads both generator registers with all ones. After reset, in random mode, the first output bit is 1 in either line mode.
- R2: With pattern select 00 and alternate-source 0, the output equals the user transmit data bit in the same cycle.
- R3: Pattern select 01 drives a constant 1, whatever the alternate-source, invert and data inputs are.
- R4: Pattern select 00 with alternate-source 1 drives a constant 0, whatever the data and invert inputs are.
- R5: Pattern select 11 is reserved and passes the user data bit whatever the alternate-source input is.
- R6: Pattern select 10 with line mode 0 (E1) outputs the most significant bit of a 15-bit Fibonacci register. On each strobe the register shifts toward its most significant end and takes in bit14 XOR bit13 (polynomial x^15+x^14+1). The sequence has period 32767.
- R7: Pattern select 10 with line mode 1 (T1/J1) uses a 20-bit register with feedback bit19 XOR bit16 (x^20+x^17+1). The output is bit19, forced to 1 whenever bits 18 down to 5 are all zero.
- R8: In T1/J1 random mode, no more than 14 consecutive zero bits appear on the output.
- R9: The invert input complements the random pattern only. It has no effect in the pass-through, all-ones, all-zeros and reserved modes.
- R10: The generators advance only on cycles with the bit-enable strobe high. Without a strobe, the random output holds its value.
- R11: A generator register never reaches the all-zero state. In E1 mode the output therefore never shows more than 14 consecutive zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | Bit strobe; advances the generators |
| pat_sel | input | 2 | Pattern select: 00 pass/zeros, 01 ones, 10 random, 11 reserved (pass) |
| alt_src | input | 1 | Alternate-source select; with pattern 00 turns the output into all zeros |
| t1_mode | input | 1 | 0: 15-stage PRBS (E1); 1: 20-stage zero-limited QRSS (T1/J1) |
| invert | input | 1 | Complements the random pattern |
| tx_data_in | input | 1 | User transmit data bit |
| line_bit | output | 1 | Selected transmit bit |

## Verification
The output-select properties are sampled at the rising edge. They assume that every control input and the user data bit are settled and free of X at that edge. The zero-run property counts only the bits taken on strobe cycles, so it assumes the strobe is the sole qualifier of a transmitted bit. The stimulus changes all inputs on the falling edge and reads the output one nanosecond later. Between strobes it never alters the controls in a way that the properties do not allow.

// File: rtl/lpg_pkg.sv
package lpg_pkg;

    localparam int E1_LEN     = 15;
    localparam int E1_TAP     = 14;
    localparam int T1_LEN     = 20;
    localparam int T1_TAP     = 17;
    localparam int QRSS_ZLIM  = 14;

    typedef enum logic [1:0] {
        PAT_PASS = 2'b00,
        PAT_ONES = 2'b01,
        PAT_RAND = 2'b10,
        PAT_RSVD = 2'b11
    } pat_e;

    typedef struct packed {
        pat_e pat;
        logic alt_src;
        logic user_bit;
        logic rnd_bit;
    } sel_t;

    function automatic logic pick_bit(sel_t s);
        logic b;
        case (s.pat)
            PAT_PASS: b = s.alt_src ? 1'b0 : s.user_bit;
            PAT_ONES: b = 1'b1;
            PAT_RAND: b = s.rnd_bit;
            default:  b = s.user_bit;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/lpg_lfsr.sv
module lpg_lfsr #(
    parameter int LEN   = 15,
    parameter int TAP   = 14,
    parameter int OUT_W = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             adv,
    output logic [OUT_W-1:0] head
);
    localparam logic [LEN-1:0] SEED = {LEN{1'b1}};

    logic [LEN-1:0] state_q;
    logic [LEN-1:0] state_d;

    always_comb begin
        state_d = {state_q[LEN-2:0], state_q[LEN-1] ^ state_q[TAP-1]};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEED;
        end else if (adv) begin
            state_q <= state_d;
        end
    end

    assign head = state_q[LEN-1 -: OUT_W];

    AST_NO_LOCKUP: assert property (@(posedge clk) disable iff (rst)
        state_q != '0); // R11

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable(state_q)); // R10

    AST_MOVES_ON_STROBE: assert property (@(posedge clk) disable iff (rst)
        adv |=> state_q != $past(state_q)); // R10

endmodule

// File: rtl/lpg_zlim.sv
module lpg_zlim #(
    parameter int LIMIT = 14
) (
    input  logic [LIMIT:0] win,
    output logic           bit_out
);
    logic ahead_clear;

    always_comb begin
        ahead_clear = ~|win[LIMIT-1:0];
        bit_out     = win[LIMIT] | ahead_clear;
    end

endmodule

// File: rtl/lpg_outsel.sv
module lpg_outsel
    import lpg_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  sel_t sel,
    output logic line_bit
);
    always_comb begin
        line_bit = pick_bit(sel);
    end

    AST_PASS_THRU: assert property (@(posedge clk) disable iff (rst)
        (sel.pat == PAT_PASS && !sel.alt_src) |-> line_bit == sel.user_bit); // R2

    AST_ALL_ONES: assert property (@(posedge clk) disable iff (rst)
        (sel.pat == PAT_ONES) |-> line_bit); // R3

    AST_ALL_ZEROS: assert property (@(posedge clk) disable iff (rst)
        (sel.pat == PAT_PASS && sel.alt_src) |-> !line_bit); // R4

    AST_RSVD_PASS: assert property (@(posedge clk) disable iff (rst)
        (sel.pat == PAT_RSVD) |-> line_bit == sel.user_bit); // R5

endmodule

// File: rtl/line_pattern_gen.sv
module line_pattern_gen
    import lpg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       bit_en,
    input  logic [1:0] pat_sel,
    input  logic       alt_src,
    input  logic       t1_mode,
    input  logic       invert,
    input  logic       tx_data_in,
    output logic       line_bit
);
    localparam int RUN_W = $clog2(QRSS_ZLIM + 2);

    logic                 prbs_bit;
    logic [QRSS_ZLIM:0]   qrss_win;
    logic                 qrss_bit;
    logic                 rnd_bit;
    sel_t                 sel;

    lpg_lfsr #(.LEN(E1_LEN), .TAP(E1_TAP), .OUT_W(1)) u_e1_gen (
        .clk  (clk),
        .rst  (rst),
        .adv  (bit_en),
        .head (prbs_bit)
    );

    lpg_lfsr #(.LEN(T1_LEN), .TAP(T1_TAP), .OUT_W(QRSS_ZLIM + 1)) u_t1_gen (
        .clk  (clk),
        .rst  (rst),
        .adv  (bit_en),
        .head (qrss_win)
    );

    lpg_zlim #(.LIMIT(QRSS_ZLIM)) u_zlim (
        .win     (qrss_win),
        .bit_out (qrss_bit)
    );

    always_comb begin
        rnd_bit      = (t1_mode ? qrss_bit : prbs_bit) ^ invert;
        sel.pat      = pat_e'(pat_sel);
        sel.alt_src  = alt_src;
        sel.user_bit = tx_data_in;
        sel.rnd_bit  = rnd_bit;
    end

    lpg_outsel u_outsel (
        .clk      (clk),
        .rst      (rst),
        .sel      (sel),
        .line_bit (line_bit)
    );

    // zero-run watch on the limited sequence, for the assertion below
    logic [RUN_W-1:0] zrun_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            zrun_q <= '0;
        end else if (bit_en) begin
            if (qrss_bit) begin
                zrun_q <= '0;
            end else if (zrun_q != {RUN_W{1'b1}}) begin
                zrun_q <= zrun_q + 1'b1;
            end
        end
    end

    AST_ZERO_RUN: assert property (@(posedge clk) disable iff (rst)
        zrun_q <= RUN_W'(QRSS_ZLIM)); // R8

    AST_RSEED_ONE: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (prbs_bit && qrss_bit)); // R1

endmodule

// File: tb/line_pattern_gen_bench.sv
`timescale 1ns/1ps
module line_pattern_gen_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bit_en = 1'b0;
    logic [1:0] pat_sel = 2'b00;
    logic       alt_src = 1'b0;
    logic       t1_mode = 1'b0;
    logic       invert = 1'b0;
    logic       tx_data_in = 1'b0;
    logic       line_bit;

    always #2.5 clk = ~clk;

    line_pattern_gen u_line_pattern_gen (
        .clk        (clk),
        .rst        (rst),
        .bit_en     (bit_en),
        .pat_sel    (pat_sel),
        .alt_src    (alt_src),
        .t1_mode    (t1_mode),
        .invert     (invert),
        .tx_data_in (tx_data_in),
        .line_bit   (line_bit)
    );

    int n_checks = 0;
    int n_errors = 0;
    logic [14:0] m_e1 = '1;
    logic [19:0] m_t1 = '1;

    // {pat_sel, alt_src, data, invert, expected}
    localparam logic [5:0] VEC [0:10] = '{
        6'b00_0_0_0_0,  // R2
        6'b00_0_1_0_1,  // R2
        6'b00_0_1_1_1,  // R2, R9
        6'b00_1_1_0_0,  // R4
        6'b00_1_0_1_0,  // R4, R9
        6'b01_0_0_0_1,  // R3
        6'b01_1_0_1_1,  // R3, R9
        6'b11_0_1_0_1,  // R5
        6'b11_0_0_0_0,  // R5
        6'b11_1_1_0_1,  // R5
        6'b11_1_0_1_0   // R5, R9
    };

    task automatic chk(input bit ok, input string tag, input int got, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    function automatic logic model_bit(input logic [1:0] p, input logic a, input logic ud,
                                       input logic t1, input logic inv);
        logic rnd;
        rnd = t1 ? (m_t1[19] | (m_t1[18:5] == 14'd0)) : m_e1[14];
        rnd = rnd ^ inv;
        case (p)
            2'b00:   return a ? 1'b0 : ud;
            2'b01:   return 1'b1;
            2'b10:   return rnd;
            default: return ud;
        endcase
    endfunction

    task automatic step(input logic [1:0] p, input logic a, input logic ud, input logic t1,
                        input logic inv, input logic en, output logic got, output logic exp);
        @(negedge clk);
        pat_sel = p; alt_src = a; tx_data_in = ud; t1_mode = t1; invert = inv; bit_en = en;
        #1;
        got = line_bit;
        exp = model_bit(p, a, ud, t1, inv);
        if (en) begin
            m_e1 = {m_e1[13:0], m_e1[14] ^ m_e1[13]};
            m_t1 = {m_t1[18:0], m_t1[19] ^ m_t1[16]};
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; bit_en = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        m_e1 = '1;
        m_t1 = '1;
    endtask

    task automatic run_seq(input logic t1, input logic inv, input int n,
                           output int mism, output int maxrun);
        logic g, e;
        int run;
        mism = 0; maxrun = 0; run = 0;
        for (int i = 0; i < n; i++) begin
            step(2'b10, 1'b0, 1'b0, t1, inv, 1'b1, g, e);
            if (g !== e) mism++;
            if (g === 1'b0) run++; else run = 0;
            if (run > maxrun) maxrun = run;
        end
    endtask

    initial begin
        #950000;
        n_errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        logic g, e;
        int mism, maxrun;
        logic [19:0] first_bits, later_bits;

        do_reset();

        // R1: seed of all ones gives 1 first in both line modes
        step(2'b10, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, g, e);
        chk(g === 1'b1, "R1 e1 first bit", g, 1);
        step(2'b10, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, g, e);
        chk(g === 1'b1, "R1 t1 first bit", g, 1);

        // table of static modes
        for (int i = 0; i < 11; i++) begin
            logic [5:0] v;
            string tag;
            v = VEC[i];
            if (v[5:4] == 2'b01) tag = "R3";
            else if (v[5:4] == 2'b11) tag = "R5";
            else if (v[3]) tag = "R4";
            else tag = "R2";
            if (v[1]) tag = {tag, "/R9"};
            step(v[5:4], v[3], v[2], 1'b0, v[1], 1'b0, g, e);
            chk(g === v[0], tag, g, v[0]);
        end

        // R10: no strobe, random output holds
        mism = 0;
        for (int i = 0; i < 8; i++) begin
            step(2'b10, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, g, e);
            if (g !== 1'b1) mism++;
        end
        chk(mism == 0, "R10 hold without strobe", mism, 0);

        // R6: full E1 period, compared against the polynomial
        for (int i = 0; i < 20; i++) begin
            step(2'b10, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, g, e);
            first_bits[i] = g;
            if (g !== e) mism++;
        end
        run_seq(1'b0, 1'b0, 32767 - 20, mism, maxrun);
        chk(mism == 0, "R6 E1 sequence mismatches", mism, 0);
        chk(maxrun <= 14, "R11 E1 longest zero run", maxrun, 14);
        for (int i = 0; i < 20; i++) begin
            step(2'b10, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, g, e);
            later_bits[i] = g;
        end
        chk(later_bits == first_bits, "R6 period 32767", int'(later_bits), int'(first_bits));

        // R9: inverted E1 stream
        run_seq(1'b0, 1'b1, 64, mism, maxrun);
        chk(mism == 0, "R9 inverted E1 mismatches", mism, 0);

        // R7 / R8: long QRSS run
        run_seq(1'b1, 1'b0, 100000, mism, maxrun);
        chk(mism == 0, "R7 QRSS sequence mismatches", mism, 0);
        chk(maxrun <= 14, "R8 QRSS longest zero run", maxrun, 14);

        // R9: inverted QRSS
        run_seq(1'b1, 1'b1, 64, mism, maxrun);
        chk(mism == 0, "R9 inverted QRSS mismatches", mism, 0);

        // R10: sparse strobes
        mism = 0;
        for (int i = 0; i < 40; i++) begin
            step(2'b10, 1'b0, 1'b0, 1'b1, 1'b0, logic'(i % 3 == 0), g, e);
            if (g !== e) mism++;
        end
        chk(mism == 0, "R10 sparse strobe mismatches", mism, 0);

        // R1: reset in mid-run restarts from the seed
        do_reset();
        mism = 0;
        for (int i = 0; i < 15; i++) begin
            step(2'b10, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, g, e);
            if (g !== 1'b1) mism++;
        end
        chk(mism == 0, "R1 ones after mid-run reset", mism, 0);
        step(2'b10, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, g, e);
        chk(g === 1'b0, "R1 first zero after seed", g, 0);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule